// File: doc/BRIEF.md
# Serial ADC Result Output Controller

This block is the digital output side of a sigma-delta converter. It steps through four states: a start-up interval after reset, a conversion, a low-power sleep and a data-output phase. A conversion-time counter stands in for the conversion engine. When that counter expires, the block takes a 24-bit result word in parallel from its data and channel inputs and holds it until a host reads it out on a serial data line.

The serial clock can come from the host or from the block itself. The block selects host-clock operation when the clock pin reads low at the end of the start-up interval. It also selects host-clock operation when the pin reads low at a falling edge of chip select. If the pin reads high at either of those moments, the block drives the clock itself while chip select is low.

Whenever no word is being shifted, the data line carries the end-of-conversion status. The first bit of every word is that same flag at 0. When the last bit has been clocked out, the next conversion starts by itself.

The parallel result input has no handshake and applies no back-pressure. It is sampled once, in the cycle the conversion counter expires. The serial output is paced only by the serial clock, so the reader sets the rate.

Top module: `adc_result_shifter`

## Requirements
- R1: After reset the block stays in a start-up interval of POR_CYC cycles, then converts for CONV_CYC cycles. Throughout both intervals the end-of-conversion flag is 1, and sdo_o reads 1 whenever chip select is low.
- R2: A conversion lasts CONV_CYC cycles. At its end the block enters sleep and sdo_o drops to 0 (EOC = 0).
- R3: When EOC falls, the block loads the word {1'b0, chan_i, data_i} (bit 23 = 0, bit 22 = channel, bits 21..0 = data) and shifts it out MSB first.
- R4: Host-clock mode is selected when the synchronized SCK is low at the end of the start-up interval or at a chip-select falling edge. In this mode the block stays asleep until the first SCK rising edge and never drives sck_oe_o.
- R5: In host-clock mode sdo_o advances one bit on each SCK falling edge and holds its value across the rising edge.
- R6: After the 24th falling edge of the serial clock, sdo_o returns to 1 and a new conversion of CONV_CYC cycles starts.
- R7: sdo_oe_o is 0 while chip select is high. Within three cycles of chip select going low, sdo_oe_o is 1 and sdo_o shows the EOC flag.
- R8: Internal-clock mode is selected when SCK reads high at a chip-select falling edge. sck_oe_o is then 1 while chip select is low. The generated clock idles low and has a half period of SCK_HALF cycles.
- R9: In internal-clock mode the block shifts a word out only while chip select is low in sleep. A word finished while chip select is high is held until chip select falls, and a word finished while chip select is low is sent at once.
- R10: Once captured, the word is not changed by data_i or chan_i until it has been shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_i | input | WORD_W-2 | Conversion result, sampled at end of conversion |
| chan_i | input | 1 | Channel identifier, sampled with data_i |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock pin level, asynchronous |
| sck_o | output | 1 | Generated serial clock |
| sck_oe_o | output | 1 | Drive enable for the generated serial clock |
| sdo_o | output | 1 | Serial data / EOC status |
| sdo_oe_o | output | 1 | Drive enable for sdo_o (0 = high impedance) |

## Verification
Chip select and SCK each pass through a two-flop synchronizer. An edge on either pin therefore acts on the system clock edge two to three cycles after it arrives, while sdo_o follows the state register with no added delay. The bench holds each host SCK level for twelve cycles and samples sdo_o near the end of the hold. It checks EOC ten cycles before and ten cycles after the computed conversion end, which covers the synchronizer slack. Internal-clock bits are sampled 1 ns after each rising edge of sck_o. At that point the data has been stable since the previous falling edge, and the spacing between the first two rising edges gives the half period.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_SHIFT = 2'd3
  } adc_state_e;
endpackage

// File: rtl/adc_pin_sync.sv
// Two-flop synchronizer with one extra stage for edge detection.
module adc_pin_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic prev_o
);
  logic [2:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {3{RST_VAL}};
    else        q <= {q[1:0], pin_i};
  end

  assign level_o = q[1];
  assign prev_o  = q[2];
endmodule

// File: rtl/adc_cycle_timer.sv
// Up-counter shared by the start-up and conversion intervals.
module adc_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt;

  assign done_o = run_i && (cnt == limit_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run_i || done_o) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt < limit_i)); // R2
endmodule

// File: rtl/adc_sck_gen.sv
// Internal serial clock divider; idles low, reports falling edges.
module adc_sck_gen #(
  parameter int SCK_HALF = 4,
  localparam int HALF_W = $clog2(SCK_HALF + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o
);
  logic [HALF_W-1:0] div;
  logic              tick;

  assign tick   = run_i && (div == HALF_W'(SCK_HALF - 1));
  assign fall_o = tick && sck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      div   <= '0;
      sck_o <= 1'b0;
    end else if (tick) begin
      div   <= '0;
      sck_o <= ~sck_o;
    end else begin
      div   <= div + 1'b1;
    end
  end

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (div < HALF_W'(SCK_HALF))); // R8
endmodule

// File: rtl/adc_out_sreg.sv
// Parallel-load, MSB-first output shift register.
module adc_out_sreg #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_o <= '0;
    else if (load_i)  word_o <= load_word_i;
    else if (shift_i) word_o <= {word_o[WORD_W-2:0], 1'b0};
  end

  assign msb_o = word_o[WORD_W-1];
endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter
  import adc_out_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int POR_CYC  = 50,
  parameter int CONV_CYC = 200,
  parameter int SCK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-3:0] data_i,
  input  logic              chan_i,
  input  logic              cs_n_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int MAX_CYC = (POR_CYC > CONV_CYC) ? POR_CYC : CONV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] POR_LIM  = CNT_W'(POR_CYC);
  localparam logic [CNT_W-1:0] CONV_LIM = CNT_W'(CONV_CYC);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  adc_state_e        state;
  logic              ext_mode;
  logic [BIT_W-1:0]  bitcnt;
  logic              cs_lvl, cs_prev, sck_lvl, sck_prev;
  logic              cs_fall, sck_rise, sck_fall;
  logic              t_run, t_done;
  logic [CNT_W-1:0]  t_limit;
  logic              gen_run, gen_fall;
  logic              shift_pulse, do_load, do_shift;
  logic              sreg_msb, eoc;
  logic [WORD_W-1:0] sreg_word, load_word;

  adc_pin_sync #(.RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cs_n_i), .level_o(cs_lvl), .prev_o(cs_prev));
  adc_pin_sync #(.RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(sck_i), .level_o(sck_lvl), .prev_o(sck_prev));

  assign cs_fall  = !cs_lvl && cs_prev;
  assign sck_rise = sck_lvl && !sck_prev;
  assign sck_fall = !sck_lvl && sck_prev;

  assign t_run   = (state == ST_POR) || (state == ST_CONV);
  assign t_limit = (state == ST_POR) ? POR_LIM : CONV_LIM;

  adc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(t_run), .limit_i(t_limit), .done_o(t_done));

  assign gen_run = (state == ST_SHIFT) && !ext_mode;

  adc_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck_gen (
    .clk(clk), .rst_n(rst_n), .run_i(gen_run), .sck_o(sck_o), .fall_o(gen_fall));

  assign load_word   = {1'b0, chan_i, data_i};
  assign do_load     = (state == ST_CONV) && t_done;
  assign shift_pulse = ext_mode ? sck_fall : gen_fall;
  assign do_shift    = (state == ST_SHIFT) && shift_pulse;

  adc_out_sreg #(.WORD_W(WORD_W)) u_sreg (
    .clk(clk), .rst_n(rst_n), .load_i(do_load), .load_word_i(load_word),
    .shift_i(do_shift), .msb_o(sreg_msb), .word_o(sreg_word));

  // Mode selection: sampled SCK level at end of start-up and at CS falling edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ext_mode <= 1'b0;
    else if (state == ST_POR && t_done)      ext_mode <= !sck_lvl;
    else if (cs_fall)                        ext_mode <= !sck_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_POR;
      bitcnt <= '0;
    end else begin
      unique case (state)
        ST_POR:   if (t_done) state <= ST_CONV;
        ST_CONV:  if (t_done) state <= ST_SLEEP;
        ST_SLEEP: begin
          if (ext_mode && sck_rise)      state <= ST_SHIFT;
          else if (!ext_mode && !cs_lvl) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (shift_pulse) begin
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              state  <= ST_CONV;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: state <= ST_POR;
      endcase
    end
  end

  assign eoc      = (state == ST_POR) || (state == ST_CONV);
  assign sdo_o    = (state == ST_SHIFT) ? sreg_msb : eoc;
  assign sdo_oe_o = !cs_lvl;
  assign sck_oe_o = !ext_mode && !cs_lvl;

  AST_LOAD_ON_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> (sreg_word == $past(load_word))); // R3
  AST_SHIFT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && $past(state) == ST_SHIFT) |-> ($past(bitcnt) == LAST_BIT)); // R6
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SHIFT) |-> !sck_o); // R8
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> $stable(sreg_word)); // R10
endmodule

// File: tb/adc_result_shifter_test.sv
`timescale 1ns/1ps
module adc_result_shifter_test;
  localparam int WORD_W = 24, POR_CYC = 50, CONV_CYC = 200, SCK_HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WORD_W-3:0] data_i = '0;
  logic chan_i = 1'b0;
  logic cs_n_i = 1'b1;
  logic ext_en = 1'b0, ext_lvl = 1'b1;
  logic sck_o, sck_oe_o, sdo_o, sdo_oe_o, sck_pin;
  int   n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign sck_pin = sck_oe_o ? sck_o : (ext_en ? ext_lvl : 1'b1);

  adc_result_shifter #(.WORD_W(WORD_W), .POR_CYC(POR_CYC), .CONV_CYC(CONV_CYC),
                       .SCK_HALF(SCK_HALF)) uut (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .chan_i(chan_i), .cs_n_i(cs_n_i),
    .sck_i(sck_pin), .sck_o(sck_o), .sck_oe_o(sck_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic read_ext(output logic [WORD_W-1:0] w);
    for (int i = 0; i < WORD_W; i++) begin
      ext_lvl = 1'b1; cyc(12);
      w[WORD_W-1-i] = sdo_o;
      ext_lvl = 1'b0; cyc(12);
    end
  endtask

  task automatic read_int(output logic [WORD_W-1:0] w, output int half);
    realtime t0 = 0;
    for (int i = 0; i < WORD_W; i++) begin
      @(posedge sck_o); #1;
      if (i == 0) t0 = $realtime;
      if (i == 1) half = int'(($realtime - t0) / 5.0) / 2;
      w[WORD_W-1-i] = sdo_o;
    end
  endtask

  // R1, R7: reset state and start-up interval
  task automatic t_reset;
    cyc(3);
    check(sdo_oe_o == 1'b0, "R7 sdo hi-z with CS high", sdo_oe_o, 0);
    ext_en = 1'b1; ext_lvl = 1'b0; cs_n_i = 1'b0;
    rst_n = 1'b1; cyc(10);
    check(sdo_oe_o == 1'b1, "R7 sdo driven with CS low", sdo_oe_o, 1);
    check(sdo_o == 1'b1, "R1 EOC high during start-up", sdo_o, 1);
  endtask

  // R2, R3, R4, R5, R6: host-clock read
  task automatic t_ext_read;
    logic [WORD_W-1:0] w, exp;
    data_i = 22'h2A5C3F; chan_i = 1'b1;
    exp = {1'b0, 1'b1, 22'h2A5C3F};
    cyc(POR_CYC + CONV_CYC - 20);
    check(sdo_o == 1'b1, "R2 EOC still high before conversion end", sdo_o, 1);
    cyc(20);
    check(sdo_o == 1'b0, "R2 EOC low after conversion", sdo_o, 0);
    cyc(100);
    check(sdo_o == 1'b0, "R4 stays asleep without SCK", sdo_o, 0);
    check(sck_oe_o == 1'b0, "R4 no SCK drive in host mode", sck_oe_o, 0);
    read_ext(w);
    check(w == exp, "R3 R5 host-clock word", w, exp);
    check(sdo_o == 1'b1, "R6 EOC high after 24th fall", sdo_o, 1);
  endtask

  // R10, R6: data changed during sleep is ignored; next conversion timing
  task automatic t_ext_hold;
    logic [WORD_W-1:0] w, exp;
    data_i = 22'h012345; chan_i = 1'b0;
    exp = {2'b00, 22'h012345};
    cyc(CONV_CYC - 25);
    check(sdo_o == 1'b1, "R6 new conversion running", sdo_o, 1);
    cyc(30);
    check(sdo_o == 1'b0, "R6 new conversion finished", sdo_o, 0);
    data_i = 22'h3FFFFF; chan_i = 1'b1;
    cyc(20);
    read_ext(w);
    check(w == exp, "R10 captured word unchanged", w, exp);
  endtask

  // R7, R8, R9: internal-clock mode
  task automatic t_int;
    logic [WORD_W-1:0] w, exp;
    int half;
    cs_n_i = 1'b1; ext_en = 1'b0;
    data_i = 22'h155AA0; chan_i = 1'b1;
    exp = {1'b0, 1'b1, 22'h155AA0};
    cyc(4);
    check(sdo_oe_o == 1'b0, "R7 hi-z after CS high", sdo_oe_o, 0);
    cyc(CONV_CYC + 60);
    check(sck_o == 1'b0, "R9 no clock while CS high", sck_o, 0);
    data_i = 22'h000001; chan_i = 1'b0;
    cs_n_i = 1'b0; cyc(3);
    check(sck_oe_o == 1'b1, "R8 SCK driven in internal mode", sck_oe_o, 1);
    read_int(w, half);
    check(w == exp, "R9 held word sent on CS low", w, exp);
    check(half == SCK_HALF, "R8 internal half period", half, SCK_HALF);
    cyc(4);
    check(sdo_o == 1'b1, "R6 EOC high after internal read", sdo_o, 1);
    data_i = 22'h2BCDEF; chan_i = 1'b0;
    exp = {2'b00, 22'h2BCDEF};
    read_int(w, half);
    check(w == exp, "R9 word sent at once with CS low", w, exp);
    cs_n_i = 1'b1; cyc(4);
    check(sdo_oe_o == 1'b0, "R7 sdo released", sdo_oe_o, 0);
    check(sck_oe_o == 1'b0, "R8 SCK released", sck_oe_o, 0);
  endtask

  // R4: host-clock mode re-selected by CS fall with SCK low
  task automatic t_reselect;
    ext_en = 1'b1; ext_lvl = 1'b0; cyc(4);
    cs_n_i = 1'b0; cyc(6);
    check(sck_oe_o == 1'b0, "R4 host mode after CS fall with SCK low", sck_oe_o, 0);
  endtask

  initial begin
    t_reset;
    t_ext_read;
    t_ext_hold;
    t_int;
    t_reselect;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule